// File: doc/BRIEF.md
# SEC-DED 72/64 Error Correcting Codec

This block protects a 64-bit data word with 8 check bits. Together they form a 72-bit stored codeword. The block has two independent combinational paths. The encoder path turns a data word into the 8 check bits that are stored beside it. The decoder path takes a 72-bit codeword read back from storage. It returns the data word, with any single flipped bit repaired, and raises one of three flags: corrected, double error or multi-bit error.

The code uses an odd-weight-column parity matrix. The 8 check bits use the eight weight-1 columns. The 64 data bits use all 56 weight-3 byte values in ascending numeric order, followed by the first 8 weight-5 byte values in ascending order.

Seven of the eight check bits are stored inverted, so the stored check byte equals the true parity XOR 8'hFE. Because of this, a word of all zeros and a word of all ones are both rejected as uncorrectable. A memory that powers up, or is cleared, to either pattern is therefore caught on its first read.

A caller with a partial write can use both paths together. It decodes the old word, merges in the new bytes, and re-encodes the result.

Top module: `secded_codec`

## Requirements
- R1: Codeword layout: bits [63:0] carry the data and bits [71:64] carry the 8 stored check bits.
- R2: Stored check bit r equals the XOR of every data bit whose matrix column has bit r set, XOR bit r of 8'hFE. Data column i is the i-th entry of the list described above: weight-3 bytes ascending, then the first 8 weight-5 bytes ascending.
- R3: A codeword formed from a data word and its own encoder output decodes to the same data with all three flags low.
- R4: A codeword with exactly one data bit flipped decodes to the original data, with only the corrected flag high.
- R5: A codeword with exactly one check bit flipped decodes to the unchanged data, with only the corrected flag high.
- R6: A codeword with exactly two bits flipped, anywhere in its 72 bits, raises only the double-error flag and returns bits [63:0] of the input unchanged.
- R7: The all-zeros 72-bit codeword raises only the multi-bit flag.
- R8: The all-ones 72-bit codeword raises only the multi-bit flag.
- R9: A nonzero odd-weight syndrome that matches no matrix column raises only the multi-bit flag and returns bits [63:0] unchanged. Flipping seven check bits of a valid word is one such case.
- R10: At most one flag is high at any time, and the returned data differs from bits [63:0] of the input in at most one bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| enc_data_i | input | 64 | Data word to encode |
| enc_check_o | output | 8 | Stored check bits for enc_data_i |
| dec_code_i | input | 72 | Codeword to decode |
| dec_data_o | output | 64 | Returned (possibly repaired) data |
| dec_corrected_o | output | 1 | One bit was repaired |
| dec_double_o | output | 1 | Two-bit error detected, data untouched |
| dec_multi_o | output | 1 | Uncorrectable pattern beyond two bits |

## Verification
Encoding and decoding share no state, so both can be active in the same cycle. The bench exercises this in every vector: it presents one data word to the encoder and, at the same time, an unrelated corrupted codeword to the decoder. The check bits and the decode result are then each compared against expectations that the bench computes from its own copy of the column rules. A cross-coupling fault would show up either as wrong check bits or as a wrong flag on the decoder output.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int DATA_W = 64;
    localparam int CHK_W  = 8;
    localparam int CODE_W = DATA_W + CHK_W;

    // Inversion applied to stored check bits. Chosen so that the syndrome of
    // the all-zeros word (8'hFE, weight 7) and of the all-ones word (8'hD9,
    // weight 5, not among the selected weight-5 columns) both land in the
    // uncorrectable class.
    localparam logic [CHK_W-1:0] STORE_INV = 8'hFE;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CHK_W-1:0]  chk_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        SYN_CLEAN  = 2'd0,
        SYN_SINGLE = 2'd1,
        SYN_DOUBLE = 2'd2,
        SYN_MULTI  = 2'd3
    } syn_class_e;

    typedef struct packed {
        data_t data;
        logic  corrected;
        logic  double_err;
        logic  multi_err;
    } dec_result_t;

    function automatic int ones8(input logic [CHK_W-1:0] v);
        int n;
        n = 0;
        for (int b = 0; b < CHK_W; b++) n += int'(v[b]);
        return n;
    endfunction

    // Data columns: every weight-3 byte ascending, then weight-5 bytes
    // ascending until DATA_W columns exist.
    function automatic logic [DATA_W*CHK_W-1:0] build_columns();
        logic [DATA_W*CHK_W-1:0] cols;
        int n;
        cols = '0;
        n = 0;
        for (int w = 3; w <= 5; w += 2) begin
            for (int v = 1; v < (1 << CHK_W); v++) begin
                if (ones8(CHK_W'(v)) == w && n < DATA_W) begin
                    cols[n*CHK_W +: CHK_W] = CHK_W'(v);
                    n++;
                end
            end
        end
        return cols;
    endfunction

    localparam logic [DATA_W*CHK_W-1:0] DATA_COLS = build_columns();

    function automatic chk_t data_col(input int i);
        return DATA_COLS[i*CHK_W +: CHK_W];
    endfunction

    // Data bits that feed check row r.
    function automatic data_t row_select(input int r);
        data_t sel;
        for (int i = 0; i < DATA_W; i++) sel[i] = DATA_COLS[i*CHK_W + r];
        return sel;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
    import secded_pkg::*;
(
    input  data_t data_i,
    output chk_t  check_o
);

    chk_t parity;

    for (genvar r = 0; r < CHK_W; r++) begin : g_row
        localparam data_t SEL = row_select(r);
        assign parity[r] = ^(data_i & SEL);
    end

    assign check_o = parity ^ STORE_INV;

endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome
    import secded_pkg::*;
(
    input  code_t code_i,
    output chk_t  syndrome_o
);

    chk_t recomputed;

    secded_encoder u_reenc (
        .data_i  (code_i[DATA_W-1:0]),
        .check_o (recomputed)
    );

    // Inversion mask is present on both sides and cancels here.
    assign syndrome_o = recomputed ^ code_i[CODE_W-1:DATA_W];

endmodule

// File: rtl/secded_corrector.sv
module secded_corrector
    import secded_pkg::*;
(
    input  data_t       data_i,
    input  chk_t        syndrome_i,
    output dec_result_t result_o
);

    data_t      flip;
    logic       check_hit;
    syn_class_e cls;

    for (genvar i = 0; i < DATA_W; i++) begin : g_match
        localparam chk_t COL = data_col(i);
        assign flip[i] = (syndrome_i == COL);
    end

    assign check_hit = (ones8(syndrome_i) == 1);

    always_comb begin
        if (syndrome_i == '0)
            cls = SYN_CLEAN;
        else if ((|flip) || check_hit)
            cls = SYN_SINGLE;
        else if (!(^syndrome_i))
            cls = SYN_DOUBLE;
        else
            cls = SYN_MULTI;
    end

    always_comb begin
        result_o.data       = (cls == SYN_SINGLE) ? (data_i ^ flip) : data_i;
        result_o.corrected  = (cls == SYN_SINGLE);
        result_o.double_err = (cls == SYN_DOUBLE);
        result_o.multi_err  = (cls == SYN_MULTI);
    end

    always_comb begin
        if (!$isunknown(syndrome_i) && !$isunknown(data_i)) begin
            AST_ONE_FLAG_MAX: assert ($onehot0({result_o.corrected, result_o.double_err, result_o.multi_err})) else $error("flags not exclusive"); // R10
            AST_AT_MOST_ONE_FLIP: assert ($countones(result_o.data ^ data_i) <= 1) else $error("more than one data bit changed"); // R10
            AST_UNCORR_DATA_KEPT: assert (!(result_o.double_err || result_o.multi_err) || (result_o.data == data_i)) else $error("uncorrectable word altered"); // R6
            AST_CLEAN_NO_FLAG: assert ((syndrome_i != '0) || !(result_o.corrected || result_o.double_err || result_o.multi_err)) else $error("flag on zero syndrome"); // R3
            AST_EVEN_IS_DOUBLE: assert ((syndrome_i == '0) || (^syndrome_i) || result_o.double_err) else $error("even syndrome not double"); // R6
        end
    end

endmodule

// File: rtl/secded_codec.sv
module secded_codec
    import secded_pkg::*;
(
    input  logic [63:0] enc_data_i,
    output logic [7:0]  enc_check_o,
    input  logic [71:0] dec_code_i,
    output logic [63:0] dec_data_o,
    output logic        dec_corrected_o,
    output logic        dec_double_o,
    output logic        dec_multi_o
);

    chk_t        syndrome;
    dec_result_t res;

    secded_encoder u_enc (
        .data_i  (enc_data_i),
        .check_o (enc_check_o)
    );

    secded_syndrome u_syn (
        .code_i     (dec_code_i),
        .syndrome_o (syndrome)
    );

    secded_corrector u_fix (
        .data_i     (dec_code_i[DATA_W-1:0]),
        .syndrome_i (syndrome),
        .result_o   (res)
    );

    assign dec_data_o      = res.data;
    assign dec_corrected_o = res.corrected;
    assign dec_double_o    = res.double_err;
    assign dec_multi_o     = res.multi_err;

    always_comb begin
        if (!$isunknown(dec_code_i)) begin
            AST_ZERO_WORD_REJECT: assert ((dec_code_i != '0) || dec_multi_o) else $error("all-zeros accepted"); // R7
            AST_ONES_WORD_REJECT: assert ((dec_code_i != '1) || dec_multi_o) else $error("all-ones accepted"); // R8
        end
    end

endmodule

// File: tb/secded_codec_test.sv
module secded_codec_test;

    logic        clk = 1'b0;
    logic [63:0] enc_data;
    logic [7:0]  enc_check;
    logic [71:0] dec_code;
    logic [63:0] dec_data;
    logic        dec_corr, dec_dbl, dec_multi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    secded_codec uut (
        .enc_data_i      (enc_data),
        .enc_check_o     (enc_check),
        .dec_code_i      (dec_code),
        .dec_data_o      (dec_data),
        .dec_corrected_o (dec_corr),
        .dec_double_o    (dec_dbl),
        .dec_multi_o     (dec_multi)
    );

    function automatic int pop(input logic [7:0] v);
        int n = 0;
        for (int b = 0; b < 8; b++) if (v[b]) n++;
        return n;
    endfunction

    function automatic logic [7:0] tb_col(input int idx);
        int n = 0;
        logic [7:0] hit = '0;
        for (int w = 3; w <= 5; w += 2)
            for (int v = 1; v < 256; v++)
                if (pop(8'(v)) == w) begin
                    if (n == idx) hit = 8'(v);
                    n++;
                end
        return hit;
    endfunction

    logic [7:0] cols [64];

    function automatic logic [7:0] tb_check(input logic [63:0] d);
        logic [7:0] p = '0;
        for (int i = 0; i < 64; i++) if (d[i]) p ^= cols[i];
        return p ^ 8'hFE;
    endfunction

    task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected decode: {data, corr, dbl, multi}
    function automatic logic [66:0] tb_decode(input logic [71:0] c);
        logic [7:0]  s = tb_check(c[63:0]) ^ c[71:64];
        logic [63:0] d = c[63:0];
        if (s == 8'h00) return {d, 3'b000};
        for (int i = 0; i < 64; i++)
            if (cols[i] == s) begin
                d[i] = ~d[i];
                return {d, 3'b100};
            end
        if (pop(s) == 1) return {d, 3'b100};
        if (pop(s) % 2 == 0) return {d, 3'b010};
        return {d, 3'b001};
    endfunction

    task automatic apply(input logic [63:0] e, input logic [71:0] c);
        @(posedge clk);
        #1;
        enc_data = e;
        dec_code = c;
        @(negedge clk);
    endtask

    function automatic logic [66:0] got();
        return {dec_data, dec_corr, dec_dbl, dec_multi};
    endfunction

    function automatic logic [63:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    initial begin
        logic [63:0] d, d2;
        logic [71:0] cw;
        void'($urandom(32'd4711));
        for (int i = 0; i < 64; i++) cols[i] = tb_col(i);
        enc_data = '0;
        dec_code = '0;

        // R7: all zeros; R2 encoder of zero data
        apply(64'h0, 72'h0);
        chk("R7 zeros word", {5'b0, got()}, {5'b0, 64'h0, 3'b001});
        chk("R2 zero data check", {64'h0, enc_check}, {64'h0, 8'hFE});

        // R8: all ones
        apply('1, '1);
        chk("R8 ones word", {5'b0, got()}, {5'b0, 64'hFFFF_FFFF_FFFF_FFFF, 3'b001});
        chk("R2 ones data check", {64'h0, enc_check}, {64'h0, tb_check('1)});

        // R9: seven check bits flipped
        d = 64'h0123_4567_89AB_CDEF;
        cw = {tb_check(d) ^ 8'h7F, d};
        apply(d, cw);
        chk("R9 seven check flips", {5'b0, got()}, {5'b0, d, 3'b001});

        for (int t = 0; t < 24; t++) begin
            d  = rnd64();
            d2 = rnd64();
            // R1 R3: clean round trip, encoder and decoder driven together
            cw = {tb_check(d2), d2};
            apply(d, cw);
            chk("R2 encoder check bits", {64'h0, enc_check}, {64'h0, tb_check(d)});
            chk("R3 clean decode", {5'b0, got()}, {5'b0, d2, 3'b000});
            chk("R1 layout round trip", {5'b0, got()}, {5'b0, tb_decode(cw)});
            // R4 R5: every single-bit position
            for (int k = 0; k < 72; k++) begin
                apply(rnd64(), cw ^ (72'h1 << k));
                if (k < 64) chk("R4 data single", {5'b0, got()}, {5'b0, d2, 3'b100});
                else        chk("R5 check single", {5'b0, got()}, {5'b0, d2, 3'b100});
            end
            // R6: random double errors
            for (int j = 0; j < 40; j++) begin
                int a = int'($urandom_range(71, 0));
                int b = int'($urandom_range(70, 0));
                logic [71:0] bad;
                if (b >= a) b++;
                bad = cw ^ (72'h1 << a) ^ (72'h1 << b);
                apply(rnd64(), bad);
                chk("R6 double", {5'b0, got()}, {5'b0, bad[63:0], 3'b010});
            end
            // R10: arbitrary garbage words
            for (int j = 0; j < 8; j++) begin
                logic [71:0] junk = {$urandom_range(255, 0), rnd64()};
                apply(rnd64(), junk);
                chk("R10 arbitrary word", {5'b0, got()}, {5'b0, tb_decode(junk)});
                chk("R10 flag count", 72'(pop({5'b0, dec_corr, dec_dbl, dec_multi}) <= 1), 72'd1);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule